// File: doc/BRIEF.md
# Vector Multiply-Accumulate Unit

This block computes one multiply-accumulate step on a 128-bit vector. It takes an accumulator vector, two source vectors and a 5-bit operation select, and returns the updated accumulator one clock later. The select sets the source element size, which can be 8, 16, 32 or 64 bits. It also picks one of three operation families. The first family does a same-width multiply and adds the product to the accumulator lane. The second does the same multiply and subtracts the product. The third is a widening multiply-accumulate whose destination lanes are twice as wide as the source lanes.

The widening family reads only half of the narrow source lanes. It reads either the even-numbered lanes or the odd-numbered lanes. It extends both operands to the destination width before multiplying, using one of three rules: both signed, both unsigned, or a mixed rule with the first operand unsigned and the second signed. Every sum and difference wraps at its lane width. There is no saturation and no overflow indication. A surrounding pipeline issues one operation per cycle with `in_valid` and collects the result when `out_valid` is high.

Top module: `simd_mac_unit`

## Requirements
- R1: `op[1:0]` selects the source element width: 0 is 8 bits, 1 is 16, 2 is 32 and 3 is 64. `op[4:2]` selects the mode: 0 multiply-add, 1 multiply-subtract, 2 even signed, 3 even unsigned, 4 even mixed, 5 odd signed, 6 odd unsigned, 7 odd mixed.
- R2: In multiply-add mode, each lane i of width EW becomes (acc[i] + a[i]*b[i]) mod 2^EW. There are 128/EW lanes.
- R3: In multiply-subtract mode, each lane i becomes (acc[i] - a[i]*b[i]) mod 2^EW.
- R4: The widening modes produce 128/(2·EW) destination lanes of width 2·EW. Destination lane i occupies bits [2·EW·i +: 2·EW]. The even modes take source lanes 2i of both sources.
- R5: The odd modes take source lanes 2i+1 of both sources.
- R6: In the signed widening modes, both selected source elements are sign-extended to 2·EW bits before the multiply.
- R7: In the unsigned widening modes, both selected source elements are zero-extended before the multiply.
- R8: In the mixed widening modes, the `src_a` element is zero-extended and the `src_b` element is sign-extended.
- R9: In the widening modes, the product is added to the destination lane of `acc_vec`, modulo 2^(2·EW).
- R10: `out_valid` equals `in_valid` delayed by one clock. `result` carries the output of the operation that was presented one clock earlier.
- R11: While `in_valid` is low, `result` keeps its previous value, whatever the other inputs do.
- R12: While `rst` is high, `out_valid` is 0 and `result` is all zeros from the next clock edge on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and select are valid this cycle |
| op | input | 5 | Operation select: mode in [4:2], element size in [1:0] |
| acc_vec | input | 128 | Accumulator / old destination vector |
| src_a | input | 128 | First multiplicand vector |
| src_b | input | 128 | Second multiplicand vector |
| out_valid | output | 1 | `result` was updated by the previous cycle's operation |
| result | output | 128 | New destination vector |

## Verification
The bench runs every one of the 32 select codes against the most-negative lane value, all ones, zero and random vectors. These patterns expose several kinds of fault:
- A design that drops the sign extension, or applies it to the wrong operand, gives different widened products for all-ones or most-negative inputs. The mixed mode is the most sensitive case, because the two operands must be extended differently.
- Swapping the even and odd lanes, or misplacing a lane slice, corrupts the random-vector results.
- Hand-computed directed cases catch a design that saturates instead of wrapping, or that adds instead of subtracts.
- A hold phase with `in_valid` low catches a design that lets its output register follow the inputs.

// File: rtl/simd_mac_pkg.sv
package simd_mac_pkg;

    localparam int OP_W      = 5;
    localparam int NUM_SIZES = 4;
    localparam int BASE_EW   = 8;

    typedef enum logic [1:0] {
        K_MADD = 2'd0,
        K_MSUB = 2'd1,
        K_WIDE = 2'd2
    } mac_kind_e;

    typedef struct packed {
        mac_kind_e  kind;
        logic [1:0] size;
        logic       odd;
        logic       a_signed;
        logic       b_signed;
    } mac_dec_t;

    function automatic mac_dec_t mac_decode(input logic [OP_W-1:0] op);
        mac_dec_t   d;
        logic [2:0] mode;
        logic [2:0] sgn;
        mode       = op[4:2];
        d.size     = op[1:0];
        d.odd      = (mode >= 3'd5);
        d.a_signed = 1'b0;
        d.b_signed = 1'b0;
        sgn        = d.odd ? (mode - 3'd3) : mode;
        case (mode)
            3'd0:    d.kind = K_MADD;
            3'd1:    d.kind = K_MSUB;
            default: d.kind = K_WIDE;
        endcase
        if (d.kind == K_WIDE) begin
            case (sgn)
                3'd2:    begin d.a_signed = 1'b1; d.b_signed = 1'b1; end
                3'd4:    begin d.a_signed = 1'b0; d.b_signed = 1'b1; end
                default: begin d.a_signed = 1'b0; d.b_signed = 1'b0; end
            endcase
        end
        return d;
    endfunction

endpackage

// File: rtl/simd_mac_lane_same.sv
module simd_mac_lane_same #(
    parameter int EW = 8
) (
    input  logic [EW-1:0] acc,
    input  logic [EW-1:0] a,
    input  logic [EW-1:0] b,
    input  logic          sub,
    output logic [EW-1:0] res
);
    logic [EW-1:0] prod_lo;

    always_comb begin
        prod_lo = a * b;
        res     = sub ? (acc - prod_lo) : (acc + prod_lo);
    end
endmodule

// File: rtl/simd_mac_lane_wide.sv
module simd_mac_lane_wide #(
    parameter int EW = 8
) (
    input  logic [2*EW-1:0] acc,
    input  logic [2*EW-1:0] pair_a,
    input  logic [2*EW-1:0] pair_b,
    input  logic            odd,
    input  logic            a_signed,
    input  logic            b_signed,
    output logic [2*EW-1:0] res
);
    localparam int DW = 2 * EW;

    logic [EW-1:0] a_el, b_el;
    logic [DW-1:0] a_ext, b_ext, prod;

    always_comb begin
        a_el  = odd ? pair_a[DW-1:EW] : pair_a[EW-1:0];
        b_el  = odd ? pair_b[DW-1:EW] : pair_b[EW-1:0];
        a_ext = {{EW{a_signed & a_el[EW-1]}}, a_el};
        b_ext = {{EW{b_signed & b_el[EW-1]}}, b_el};
        prod  = a_ext * b_ext;
        res   = acc + prod;
    end
endmodule

// File: rtl/simd_mac_unit.sv
module simd_mac_unit
    import simd_mac_pkg::*;
#(
    parameter int VLEN = 128
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [OP_W-1:0] op,
    input  logic [VLEN-1:0] acc_vec,
    input  logic [VLEN-1:0] src_a,
    input  logic [VLEN-1:0] src_b,
    output logic            out_valid,
    output logic [VLEN-1:0] result
);
    mac_dec_t        dec;
    logic            is_sub;
    logic [VLEN-1:0] same_sel, wide_sel, nxt;

    assign dec    = mac_decode(op);
    assign is_sub = (dec.kind == K_MSUB);

    for (genvar s = 0; s < NUM_SIZES; s++) begin : g_sz
        localparam int EW = BASE_EW << s;
        localparam int NL = VLEN / EW;
        localparam int NW = VLEN / (2 * EW);

        logic [VLEN-1:0] same_v;
        logic [VLEN-1:0] wide_v;

        for (genvar l = 0; l < NL; l++) begin : g_same
            simd_mac_lane_same #(.EW(EW)) u_lane (
                .acc (acc_vec[l*EW +: EW]),
                .a   (src_a[l*EW +: EW]),
                .b   (src_b[l*EW +: EW]),
                .sub (is_sub),
                .res (same_v[l*EW +: EW])
            );
        end

        for (genvar w = 0; w < NW; w++) begin : g_wide
            simd_mac_lane_wide #(.EW(EW)) u_lane (
                .acc      (acc_vec[w*2*EW +: 2*EW]),
                .pair_a   (src_a[w*2*EW +: 2*EW]),
                .pair_b   (src_b[w*2*EW +: 2*EW]),
                .odd      (dec.odd),
                .a_signed (dec.a_signed),
                .b_signed (dec.b_signed),
                .res      (wide_v[w*2*EW +: 2*EW])
            );
        end
    end

    always_comb begin
        case (dec.size)
            2'd0:    begin same_sel = g_sz[0].same_v; wide_sel = g_sz[0].wide_v; end
            2'd1:    begin same_sel = g_sz[1].same_v; wide_sel = g_sz[1].wide_v; end
            2'd2:    begin same_sel = g_sz[2].same_v; wide_sel = g_sz[2].wide_v; end
            default: begin same_sel = g_sz[3].same_v; wide_sel = g_sz[3].wide_v; end
        endcase
        nxt = (dec.kind == K_WIDE) ? wide_sel : same_sel;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            result    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                result <= nxt;
            end
        end
    end
endmodule

// File: rtl/simd_mac_checker.sv
module simd_mac_checker #(
    parameter int VLEN = 128
) (
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [4:0]      op,
    input logic [VLEN-1:0] acc_vec,
    input logic [VLEN-1:0] src_a,
    input logic [VLEN-1:0] src_b,
    input logic            out_valid,
    input logic [VLEN-1:0] result
);
    AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (!out_valid && result == '0)); // R12
    AST_VALID_FOLLOW: assert property (@(posedge clk) disable iff (rst) in_valid |=> out_valid); // R10
    AST_VALID_DROP: assert property (@(posedge clk) disable iff (rst) !in_valid |=> !out_valid); // R10
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) !in_valid |=> $stable(result)); // R11
    AST_ADD_ZERO_A: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[4:2] == 3'd0 && src_a == '0) |=> (result == $past(acc_vec))); // R2
    AST_SUB_ZERO_B: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[4:2] == 3'd1 && src_b == '0) |=> (result == $past(acc_vec))); // R3
    AST_WIDE_ZERO_B: assert property (@(posedge clk) disable iff (rst)
        (in_valid && op[4:2] >= 3'd2 && src_b == '0) |=> (result == $past(acc_vec))); // R9
endmodule

bind simd_mac_unit simd_mac_checker #(.VLEN(VLEN)) u_chk (.*);

// File: tb/simd_mac_unit_tb.sv
`timescale 1ns/1ps
module simd_mac_unit_tb;
    logic         clk = 1'b0;
    logic         rst;
    logic         in_valid;
    logic [4:0]   op;
    logic [127:0] acc_vec, src_a, src_b;
    logic         out_valid;
    logic [127:0] result;

    int checks = 0;
    int errors = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    simd_mac_unit u_dut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .op(op),
        .acc_vec(acc_vec), .src_a(src_a), .src_b(src_b),
        .out_valid(out_valid), .result(result)
    );

    function automatic logic [127:0] model(input logic [4:0] o, input logic [127:0] d,
                                           input logic [127:0] a, input logic [127:0] b);
        logic [255:0] dd, aa, bb, m_ew, m_dw, ax, bx, dx, p, r, acc;
        int ew, dw, mode, sel;
        bit sa, sb;
        mode = int'(o[4:2]);
        ew   = 8 << o[1:0];
        dw   = 2 * ew;
        dd = {128'd0, d}; aa = {128'd0, a}; bb = {128'd0, b};
        m_ew = (256'd1 << ew) - 256'd1;
        m_dw = (256'd1 << dw) - 256'd1;
        acc  = '0;
        if (mode < 2) begin
            for (int l = 0; l < 128 / ew; l++) begin
                ax = (aa >> (l * ew)) & m_ew;
                bx = (bb >> (l * ew)) & m_ew;
                dx = (dd >> (l * ew)) & m_ew;
                p  = ax * bx;
                r  = ((mode == 0) ? (dx + p) : (dx - p)) & m_ew;
                acc = acc | (r << (l * ew));
            end
        end else begin
            sa = (mode == 2 || mode == 5);
            sb = (mode == 2 || mode == 5 || mode == 4 || mode == 7);
            for (int l = 0; l < 128 / dw; l++) begin
                sel = 2 * l + ((mode >= 5) ? 1 : 0);
                ax = (aa >> (sel * ew)) & m_ew;
                bx = (bb >> (sel * ew)) & m_ew;
                if (sa && ax[ew-1]) ax = ax | ~m_ew;
                if (sb && bx[ew-1]) bx = bx | ~m_ew;
                dx = (dd >> (l * dw)) & m_dw;
                p  = (ax * bx) & m_dw;
                r  = (dx + p) & m_dw;
                acc = acc | (r << (l * dw));
            end
        end
        return acc[127:0];
    endfunction

    function automatic string tag_of(input logic [4:0] o);
        case (o[4:2])
            3'd0: return "R2 R1";
            3'd1: return "R3 R1";
            3'd2: return "R4 R6 R9";
            3'd3: return "R4 R7 R9";
            3'd4: return "R4 R8 R9";
            3'd5: return "R5 R6 R9";
            3'd6: return "R5 R7 R9";
            default: return "R5 R8 R9";
        endcase
    endfunction

    function automatic logic [127:0] min_vec(input int ew);
        logic [127:0] v = '0;
        for (int l = 0; l < 128 / ew; l++) v[l*ew + ew - 1] = 1'b1;
        return v;
    endfunction

    task automatic apply(input logic [4:0] o, input logic [127:0] d, input logic [127:0] a,
                         input logic [127:0] b, input logic [127:0] exp, input string tag);
        op = o; acc_vec = d; src_a = a; src_b = b; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (!out_valid || result !== exp) begin
            errors++;
            $display("FAIL %s op=%0d valid=%0b got %h expected %h", tag, o, out_valid, result, exp);
        end
    endtask

    task automatic run_model(input logic [4:0] o, input logic [127:0] d,
                             input logic [127:0] a, input logic [127:0] b);
        apply(o, d, a, b, model(o, d, a, b), tag_of(o));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] held;
        rst = 1'b1; in_valid = 1'b0; op = '0;
        acc_vec = '1; src_a = '1; src_b = '1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;   // R12 reset state
        if (out_valid !== 1'b0 || result !== '0) begin
            errors++;
            $display("FAIL R12 got valid=%0b result=%h expected 0/0", out_valid, result);
        end
        rst = 1'b0;

        // Directed hand-computed cases
        apply(5'b000_00, '0, {16{8'h80}}, {16{8'h02}}, '0, "R2 wrap");
        apply(5'b001_01, '0, {8{16'h0001}}, {8{16'h0001}}, '1, "R3 borrow");
        apply(5'b111_00, '0, '1, '1, {8{16'hFF01}}, "R8 mixed odd");
        apply(5'b010_00, '0, '1, '1, {8{16'h0001}}, "R6 signed even");
        apply(5'b011_00, '0, '1, '1, {8{16'hFE01}}, "R7 unsigned even");
        apply(5'b101_00, {8{16'h0000}}, {8{16'h0300}}, {8{16'h0500}}, {8{16'h000F}}, "R5 odd pick");
        apply(5'b010_00, {8{16'h0000}}, {8{16'h0300}}, {8{16'h0500}}, '0, "R4 even pick");
        apply(5'b011_00, '1, {16{8'h01}}, {16{8'h01}}, '0, "R9 acc wrap");

        // Hold: R10 and R11
        held = result;
        op = 5'b000_00; acc_vec = 128'h1234; src_a = 128'h5; src_b = 128'h7; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || result !== held) begin
            errors++;
            $display("FAIL R11 R10 got valid=%0b result=%h expected 0/%h", out_valid, result, held);
        end

        // Sweep every select code
        for (int o = 0; o < 32; o++) begin
            logic [4:0] oc = 5'(o);
            logic [127:0] mn = min_vec(8 << oc[1:0]);
            run_model(oc, '0, mn, mn);
            run_model(oc, '1, mn, '1);
            run_model(oc, mn, '1, '1);
            run_model(oc, '1, '0, mn);
            for (int k = 0; k < 24; k++) begin
                run_model(oc, {$urandom, $urandom, $urandom, $urandom},
                              {$urandom, $urandom, $urandom, $urandom},
                              {$urandom, $urandom, $urandom, $urandom});
            end
        end

        // Back-to-back issue, R10
        op = 5'b000_10; acc_vec = 128'd1; src_a = 128'd2; src_b = 128'd3; in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        op = 5'b001_10; acc_vec = 128'd10; src_a = 128'd1; src_b = 128'd4;
        checks++;
        if (out_valid !== 1'b1 || result !== 128'd7) begin
            errors++;
            $display("FAIL R10 first got %h expected %h", result, 128'd7);
        end
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        checks++;
        if (out_valid !== 1'b1 || result !== 128'd6) begin
            errors++;
            $display("FAIL R10 second got %h expected %h", result, 128'd6);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule